// File: doc/BRIEF.md
# Qualified Performance Event Counter

This block counts a hardware event after passing it through a fixed cascade of four qualification stages. Each cycle every event source presents a small count of how often its event class occurred in that cycle. A source selector picks one of these. A privilege filter passes or drops the cycle according to the current privilege level. A threshold stage can then turn the count into a single qualified event, either when the count exceeds a programmed threshold or, with complement set, when it does not. A last stage can restrict counting to the rising transitions of that qualified signal. What comes out of the cascade is added to a 40-bit accumulator that sets a sticky overflow flag when it wraps.

Software programs the stages and the accumulator through a simple write port with a 2-bit address. Address 0 holds the control word. Addresses 1 and 2 load the lower 32 and the upper 8 bits of the accumulator. Address 3 clears the overflow flag. All stage state sits behind registered configuration, so a write acts on the following clock. The reset input is asynchronous active-low and must already be synchronized to `clk` by the integrator.

Top module: `qec_counter`

## Requirements
- R1: After reset `count_o` is 0, `ovf_o` is 0 and the control word is all zero, so nothing is counted until software writes the control word.
- R2: A write to address 0 is used from the clock edge after the write edge. Events presented in the write cycle itself are qualified with the old settings. The control word holds: bit 0 supervisor enable, bit 1 user enable, bit 2 compare enable, bit 3 complement, bit 4 edge enable, bits 9:8 source select and bits 19:16 threshold.
- R3: Only the source chosen by the select field contributes. Source k occupies bits 4k+3:4k of `evt_vec_i`.
- R4: A cycle with `user_mode_i`=1 is counted only when user enable is set, and a cycle with `user_mode_i`=0 only when supervisor enable is set. A rejected cycle contributes nothing at any later stage. With both enables clear, the count never changes.
- R5: With compare and edge disabled, each accepted cycle adds the full 4-bit count of the selected source.
- R6: With compare enabled and complement clear, an accepted cycle adds 1 when the count is strictly greater than the threshold, else 0.
- R7: With compare and complement enabled, an accepted cycle adds 1 when the count is less than or equal to the threshold, including a count of 0.
- R8: With edge enabled, the qualified signal is the threshold result when compare is on, or count non-zero when compare is off, with rejected cycles qualified as 0. The counter adds 1 only in a cycle where that signal is 1 and was 0 in the previous cycle. The previous value is tracked even while edge mode is off.
- R9: Writes to address 1 and 2 replace the low 32 bits and the high 8 bits of the counter. In that cycle the write wins over any increment, and the other part keeps the value it would otherwise have taken.
- R10: When an increment carries out of bit 39, the counter wraps modulo 2^40 and `ovf_o` rises. It stays set until a write to address 3. A carry in the same cycle as that write keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_vec_i | input | 16 | Per-cycle event counts, 4 bits per source, source 0 in the low bits |
| user_mode_i | input | 1 | Current privilege level: 1 user, 0 supervisor |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration write address |
| cfg_wdata_i | input | 32 | Configuration write data |
| count_o | output | 40 | Accumulated count |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench sweeps every source, every combination of the five mode flags and thresholds at both ends and in the middle of the range. It compares the counter against an arithmetic model on every cycle, so a stage applied in the wrong order shows up at once. One example is complement applied before the privilege gate, which would count rejected cycles as "at or below threshold". Other failures it targets are an off-by-one on the threshold boundary (>= in place of >), an edge detector that forgets its history while edge mode is off, and a configuration write that acts in its own cycle. Wrap-around from the all-ones counter checks that the overflow flag sets, holds and clears only on its own write. It also checks that a preload overrides a concurrent increment.

// File: rtl/qec_pkg.sv
package qec_pkg;

  // Configuration write addresses
  localparam int unsigned QEC_ADDR_CTRL    = 0;
  localparam int unsigned QEC_ADDR_CNT_LO  = 1;
  localparam int unsigned QEC_ADDR_CNT_HI  = 2;
  localparam int unsigned QEC_ADDR_OVF_CLR = 3;

  // Control word field positions
  localparam int unsigned QEC_FLAG_W   = 5;
  localparam int unsigned QEC_SEL_LSB  = 8;
  localparam int unsigned QEC_THR_LSB  = 16;

  // Mode flags, en_sup in bit 0
  typedef struct packed {
    logic edge_en;
    logic cmp_inv;
    logic cmp_en;
    logic en_usr;
    logic en_sup;
  } qec_flags_t;

endpackage

// File: rtl/qec_cfg_regs.sv
module qec_cfg_regs
  import qec_pkg::*;
#(
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned EVT_W  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output qec_flags_t        flags_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [EVT_W-1:0]  thr_o
);

  qec_flags_t       flags_q, flags_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [EVT_W-1:0] thr_q, thr_d;
  logic             ctrl_wr;
  logic             unused_wdata;

  assign ctrl_wr      = we_i && (addr_i == ADDR_W'(QEC_ADDR_CTRL));
  assign unused_wdata = ^wdata_i;

  always_comb begin
    flags_d = flags_q;
    sel_d   = sel_q;
    thr_d   = thr_q;
    if (ctrl_wr) begin
      flags_d = qec_flags_t'(wdata_i[QEC_FLAG_W-1:0]);
      sel_d   = wdata_i[QEC_SEL_LSB +: SEL_W];
      thr_d   = wdata_i[QEC_THR_LSB +: EVT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      sel_q   <= '0;
      thr_q   <= '0;
    end else if (ctrl_wr) begin
      flags_q <= flags_d;
      sel_q   <= sel_d;
      thr_q   <= thr_d;
    end
  end

  assign flags_o = flags_q;
  assign sel_o   = sel_q;
  assign thr_o   = thr_q;

  // R2
  ctrl_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (sel_o == $past(wdata_i[QEC_SEL_LSB +: SEL_W]))
             && (thr_o == $past(wdata_i[QEC_THR_LSB +: EVT_W])));

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(flags_o) && $stable(sel_o) && $stable(thr_o));

endmodule

// File: rtl/qec_src_mux.sv
module qec_src_mux #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned EVT_W   = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic [NUM_SRC*EVT_W-1:0] evt_vec_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic [EVT_W-1:0]         evt_o
);

  logic [EVT_W-1:0] src_arr [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign src_arr[g] = evt_vec_i[g*EVT_W +: EVT_W];
  end

  always_comb begin
    evt_o = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (sel_i == SEL_W'(k)) evt_o = src_arr[k];
    end
  end

endmodule

// File: rtl/qec_priv_filter.sv
module qec_priv_filter #(
  parameter int unsigned EVT_W = 4
) (
  input  logic [EVT_W-1:0] evt_i,
  input  logic             user_i,
  input  logic             en_sup_i,
  input  logic             en_usr_i,
  output logic [EVT_W-1:0] evt_o,
  output logic             pass_o
);

  always_comb begin
    pass_o = user_i ? en_usr_i : en_sup_i;
    evt_o  = pass_o ? evt_i : '0;
  end

endmodule

// File: rtl/qec_thresh_edge.sv
module qec_thresh_edge #(
  parameter int unsigned EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             pass_i,
  input  logic [EVT_W-1:0] thr_i,
  input  logic             cmp_en_i,
  input  logic             cmp_inv_i,
  input  logic             edge_en_i,
  output logic [EVT_W-1:0] inc_o
);

  logic prev_q, prev_d;
  logic above, hit, qual, rise;

  always_comb begin
    above = evt_i > thr_i;
    hit   = cmp_inv_i ? !above : above;
    qual  = pass_i && (cmp_en_i ? hit : (evt_i != '0));
    rise  = qual && !prev_q;
    prev_d = qual;
    if (edge_en_i)     inc_o = {{(EVT_W-1){1'b0}}, rise};
    else if (cmp_en_i) inc_o = {{(EVT_W-1){1'b0}}, qual};
    else               inc_o = evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  // R6
  cmp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en_i |-> (inc_o <= EVT_W'(1)));

  // R8
  edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_en_i && inc_o != '0) |=> !(edge_en_i && inc_o != '0));

  // R7
  inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_i && cmp_en_i && cmp_inv_i && !edge_en_i && evt_i == '0) |-> (inc_o == EVT_W'(1)));

endmodule

// File: rtl/qec_accum.sv
module qec_accum
  import qec_pkg::*;
#(
  parameter int unsigned CNT_W  = 40,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EVT_W  = 4,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  inc_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o
);

  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;
  logic             ovf_q, ovf_d;
  logic             wr_lo, wr_hi, wr_clr;
  logic             unused_wdata;

  assign wr_lo  = we_i && (addr_i == ADDR_W'(QEC_ADDR_CNT_LO));
  assign wr_hi  = we_i && (addr_i == ADDR_W'(QEC_ADDR_CNT_HI));
  assign wr_clr = we_i && (addr_i == ADDR_W'(QEC_ADDR_OVF_CLR));
  assign unused_wdata = ^wdata_i[DATA_W-1:HI_W];

  always_comb begin
    sum   = {1'b0, cnt_q} + {{(CNT_W+1-EVT_W){1'b0}}, inc_i};
    cnt_d = sum[CNT_W-1:0];
    if (wr_lo) cnt_d[DATA_W-1:0]     = wdata_i;
    if (wr_hi) cnt_d[CNT_W-1:DATA_W] = wdata_i[HI_W-1:0];
    ovf_d = ovf_q;
    if (wr_clr)    ovf_d = 1'b0;
    if (sum[CNT_W]) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> count_o == $past(count_o) + CNT_W'($past(inc_i)));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !wr_clr) |=> ovf_o);

  // R10
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> ($past(count_o) > count_o) || $past(wr_lo) || $past(wr_hi));

endmodule

// File: rtl/qec_counter.sv
module qec_counter
  import qec_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned EVT_W   = 4,
  parameter int unsigned CNT_W   = 40,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC*EVT_W-1:0] evt_vec_i,
  input  logic                     user_mode_i,
  input  logic                     cfg_we_i,
  input  logic [ADDR_W-1:0]        cfg_addr_i,
  input  logic [DATA_W-1:0]        cfg_wdata_i,
  output logic [CNT_W-1:0]         count_o,
  output logic                     ovf_o
);

  localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  qec_flags_t       flags;
  logic [SEL_W-1:0] sel;
  logic [EVT_W-1:0] thr;
  logic [EVT_W-1:0] src_evt, priv_evt, inc;
  logic             pass;

  qec_cfg_regs #(
    .SEL_W(SEL_W), .EVT_W(EVT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .flags_o(flags), .sel_o(sel), .thr_o(thr)
  );

  qec_src_mux #(
    .NUM_SRC(NUM_SRC), .EVT_W(EVT_W), .SEL_W(SEL_W)
  ) i_mux (
    .evt_vec_i(evt_vec_i), .sel_i(sel), .evt_o(src_evt)
  );

  qec_priv_filter #(
    .EVT_W(EVT_W)
  ) i_priv (
    .evt_i(src_evt), .user_i(user_mode_i), .en_sup_i(flags.en_sup),
    .en_usr_i(flags.en_usr), .evt_o(priv_evt), .pass_o(pass)
  );

  qec_thresh_edge #(
    .EVT_W(EVT_W)
  ) i_thr (
    .clk(clk), .rst_n(rst_n), .evt_i(priv_evt), .pass_i(pass), .thr_i(thr),
    .cmp_en_i(flags.cmp_en), .cmp_inv_i(flags.cmp_inv),
    .edge_en_i(flags.edge_en), .inc_o(inc)
  );

  qec_accum #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .EVT_W(EVT_W), .ADDR_W(ADDR_W)
  ) i_acc (
    .clk(clk), .rst_n(rst_n), .inc_i(inc), .we_i(cfg_we_i),
    .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .count_o(count_o), .ovf_o(ovf_o)
  );

  // R4
  priv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((user_mode_i && !flags.en_usr) || (!user_mode_i && !flags.en_sup)) |-> (inc == '0));

  // R4
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags.en_usr && !flags.en_sup && !cfg_we_i) |=> $stable(count_o));

  // R3
  src_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags.cmp_en && !flags.edge_en && pass) |-> (inc == evt_vec_i[sel*EVT_W +: EVT_W]));

endmodule

// File: tb/test_qec_counter.sv
module test_qec_counter;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_vec = '0;
  logic        user_mode = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [39:0] count;
  logic        ovf;

  int checks = 0;
  int errors = 0;

  // model state
  logic [4:0]  m_flags = '0;
  logic [1:0]  m_sel = '0;
  logic [3:0]  m_thr = '0;
  logic [39:0] m_cnt = '0;
  logic        m_ovf = 1'b0;
  logic        m_prev = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #(PERIOD/2) clk = ~clk;

  qec_counter i_qec_counter (
    .clk(clk), .rst_n(rst_n), .evt_vec_i(evt_vec), .user_mode_i(user_mode),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .count_o(count), .ovf_o(ovf)
  );

  function automatic logic [31:0] mk_ctrl(input logic [1:0] sel, input logic [4:0] fl,
                                          input logic [3:0] thr);
    return {12'h0, thr, 6'h0, sel, 3'h0, fl};
  endfunction

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: starts and ends at a falling edge
  task automatic tick(input logic [15:0] ev, input logic usr, input logic w,
                      input logic [1:0] a, input logic [31:0] d);
    logic ok, q, inc1;
    logic [3:0] v, inc;
    logic [40:0] sum;
    evt_vec = ev; user_mode = usr; we = w; addr = a; wdata = d;
    @(posedge clk);
    ok = usr ? m_flags[1] : m_flags[0];
    v  = ok ? ev[m_sel*4 +: 4] : 4'h0;
    q  = ok && (m_flags[2] ? (m_flags[3] ? (v <= m_thr) : (v > m_thr)) : (v != 0));
    inc1 = q && !m_prev;
    if (m_flags[4])      inc = {3'b0, inc1};
    else if (m_flags[2]) inc = {3'b0, q};
    else                 inc = v;
    sum = {1'b0, m_cnt} + {37'b0, inc};
    m_cnt = sum[39:0];
    if (w && a == 2'd1) m_cnt[31:0] = d;
    if (w && a == 2'd2) m_cnt[39:32] = d[7:0];
    if (w && a == 2'd3) m_ovf = 1'b0;
    if (sum[40]) m_ovf = 1'b1;
    if (w && a == 2'd0) begin
      m_flags = d[4:0]; m_sel = d[9:8]; m_thr = d[19:16];
    end
    m_prev = q;
    @(negedge clk);
  endtask

  task automatic idle();
    tick(16'h0, 1'b0, 1'b0, 2'd0, 32'h0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    tick(16'h0, 1'b0, 1'b1, a, d);
  endtask

  function automatic string req_of(input logic [4:0] fl);
    if (!fl[0] && !fl[1]) return "R4";
    if (fl[4])            return "R8";
    if (fl[2] && fl[3])   return "R7";
    if (fl[2])            return "R6";
    return "R5";
  endfunction

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] thr_set [4];
    thr_set[0] = 4'd0; thr_set[1] = 4'd3; thr_set[2] = 4'd7; thr_set[3] = 4'd15;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 count", count, 40'h0);
    chk("R1 ovf", {39'h0, ovf}, 40'h0);
    rst_n = 1'b1;
    tick(16'hFFFF, 1'b0, 1'b0, 2'd0, 32'h0);
    tick(16'hFFFF, 1'b1, 1'b0, 2'd0, 32'h0);
    chk("R1 disabled after reset", count, 40'h0);

    // R2: control write acts one clock later
    tick(16'h0050, 1'b0, 1'b1, 2'd0, mk_ctrl(2'd1, 5'b00001, 4'd0));
    chk("R2 write cycle", count, 40'h0);
    tick(16'h0050, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R2 next cycle", count, 40'd5);

    // R3: other sources ignored
    tick(16'hF0FF & 16'hF00F, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R3 other sources", count, 40'd5);
    tick(16'h0F20, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R3 selected source", count, 40'd7);

    // Full sweep of sources, flags and thresholds
    for (int s = 0; s < 4; s++) begin
      for (int f = 0; f < 32; f++) begin
        for (int t = 0; t < 4; t++) begin
          wr(2'd0, mk_ctrl(2'(s), 5'(f), thr_set[t]));
          wr(2'd1, 32'h0);
          wr(2'd2, 32'h0);
          for (int c = 0; c < 12; c++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            tick((c % 5 == 4) ? 16'h0 : lfsr[15:0], lfsr[20], 1'b0, 2'd0, 32'h0);
            chk(req_of(5'(f)), count, m_cnt);
          end
        end
      end
    end

    // R7: zero count counts with complement, threshold 0 boundary
    wr(2'd0, mk_ctrl(2'd2, 5'b01101, 4'd0));
    wr(2'd1, 32'h0);
    tick(16'h0000, 1'b0, 1'b0, 2'd0, 32'h0);
    tick(16'h0100, 1'b0, 1'b0, 2'd0, 32'h0);
    tick(16'h0000, 1'b1, 1'b0, 2'd0, 32'h0);
    chk("R7 zero and boundary", count, 40'd1);

    // R6: strict greater-than at threshold 3
    wr(2'd0, mk_ctrl(2'd0, 5'b00101, 4'd3));
    wr(2'd1, 32'h0);
    tick(16'h0003, 1'b0, 1'b0, 2'd0, 32'h0);
    tick(16'h0004, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R6 boundary", count, 40'd1);

    // R8: prev tracked while edge off
    wr(2'd0, mk_ctrl(2'd0, 5'b00001, 4'd0));
    tick(16'h0001, 1'b0, 1'b0, 2'd0, 32'h0);
    tick(16'h0001, 1'b0, 1'b1, 2'd0, mk_ctrl(2'd0, 5'b10001, 4'd0));
    wr(2'd1, 32'h0);
    tick(16'h0002, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R8 no rise while high", count, m_cnt);
    tick(16'h0000, 1'b0, 1'b0, 2'd0, 32'h0);
    tick(16'h0002, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R8 rise", count, m_cnt);

    // R9: preload wins over increment
    wr(2'd0, mk_ctrl(2'd0, 5'b00001, 4'd0));
    wr(2'd2, 32'h0000_00AB);
    tick(16'h0007, 1'b0, 1'b1, 2'd1, 32'h0000_0005);
    chk("R9 write wins", count, 40'hAB_0000_0005);

    // R10: wrap and sticky overflow
    wr(2'd1, 32'hFFFF_FFFE);
    wr(2'd2, 32'h0000_00FF);
    tick(16'h0003, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R10 wrap count", count, 40'h1);
    chk("R10 ovf set", {39'h0, ovf}, 40'h1);
    idle();
    chk("R10 ovf holds", {39'h0, ovf}, 40'h1);
    wr(2'd3, 32'h0);
    chk("R10 ovf clear", {39'h0, ovf}, 40'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule